// File: doc/BRIEF.md
# Multiprocessor Interrupt Router With Level Mapping

This block is the system-wide interrupt router for a small shared-memory multiprocessor. It collects 32 device interrupt lines and one local timer line per processor into a 32-bit pending vector. It masks that vector with a 32-bit disable vector and translates each surviving source into one of fifteen processor interrupt levels through a fixed source-to-level table. All device traffic goes to a single target processor that software selects. Every processor also receives its own soft-interrupt bits, and these bypass the device routing completely.

Software works through five word-indexed registers. One register reads back the pending sources and one reads the disable state. Two write-only registers set or clear disable bits, and a set also discards the matching pending bits. The fifth register selects the target processor. The top bit of the disable vector is a global switch. When it is set, no device or timer source reaches any processor.

Each processor's 15-bit level-request vector is registered. The downstream priority encoder therefore sees a glitch-free copy of the routing state.

Top module: `irq_router`

## Requirements
- R1: After synchronous reset, the pending vector, the target (index 0) and every level output are zero. The disable vector holds 0x0fa2007f, so index 1 reads zero.
- R2: A read of index 0 returns the pending vector with bit 31 forced to zero.
- R3: A read of index 1 returns the disable vector ANDed with 0xf05dff80. The bits of 0x0fa2007f always read zero. A read of index 2, 3, 5, 6 or 7 returns zero.
- R4: A write to index 2 clears the disable bits that are set in the write data and belong to 0xf05dff80. Other bits are ignored. Writes to indices 0, 1 and 5 to 7 change nothing.
- R5: A write to index 3 sets the implemented written bits in the disable vector and clears the same bits in the pending vector. A source edge in the same cycle takes precedence over that pending clear.
- R6: A write to index 4 sets the target to the written value modulo NUM_CPU, and index 4 reads it back.
- R7: While disable bit 31 is set, each processor's level vector equals its soft-interrupt input alone.
- R8: For the target processor, the level vector has bit L-1 set for every source j that is pending and not disabled, where L = TABLE[j] (default (j mod 15)+1). Its soft bits are ORed in. A processor that is not the target sees only its soft bits. Slice k of the level and soft buses is bits [15k+14:15k], and bit i stands for level i+1.
- R9: A rising edge on device line j sets pending bit j, and a falling edge clears it.
- R10: A rising edge on any timer line sets pending bit TIMER_BIT (default 19), and a falling edge clears it. When a set and a clear of the same bit coincide, the set wins.
- R11: The level outputs change at the first clock edge after the state or soft input they depend on changes. A line edge therefore appears at the outputs two edges after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| dev_irq | input | 32 | Device interrupt lines |
| timer_irq | input | NUM_CPU | Per-processor timer lines |
| soft_irq | input | 15*NUM_CPU | Per-processor soft-interrupt bits |
| level_req | output | 15*NUM_CPU | Registered per-processor level requests |

## Verification
Directed steps first route a single device line to two different targets. This separates the table lookup from the target selection. A later step sets the global disable while soft bits are active, which shows that soft traffic is independent of device routing. Timer edges from a non-target processor, together with a device edge on the same bit, exercise the set-over-clear rule and the shared timer bit. Random phases then toggle sparse line patterns and issue writes to every index, including unused ones. A reference model compares every read index and every level slice each cycle, so any mismatch in the masks, the mapping or the write-clear/edge ordering shows up.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int SRC_N   = 32;
    localparam int LVL_W   = 4;
    localparam int NUM_LVL = 15;
    localparam int MOFF_BIT = 31;

    localparam logic [SRC_N-1:0] ABSENT_BITS = 32'h0fa2007f;
    localparam logic [SRC_N-1:0] LIVE_BITS   = ~ABSENT_BITS;

    typedef enum logic [2:0] {
        IDX_PEND   = 3'd0,
        IDX_DIS    = 3'd1,
        IDX_UNMASK = 3'd2,
        IDX_MASK   = 3'd3,
        IDX_TARGET = 3'd4
    } reg_idx_e;

    typedef struct packed {
        logic             unmask;
        logic             mask;
        logic             retarget;
        logic [SRC_N-1:0] bits;
        logic [SRC_N-1:0] raw;
    } wr_cmd_t;

    typedef struct packed {
        logic [SRC_N-1:0] set_v;
        logic [SRC_N-1:0] clr_v;
    } edge_evt_t;

    function automatic logic [SRC_N*LVL_W-1:0] default_lvl_table();
        logic [SRC_N*LVL_W-1:0] t;
        t = '0;
        for (int j = 0; j < SRC_N; j++) begin
            t[j*LVL_W +: LVL_W] = LVL_W'((j % NUM_LVL) + 1);
        end
        return t;
    endfunction

    function automatic logic [NUM_LVL-1:0] lvl_onehot(input logic [LVL_W-1:0] l);
        logic [NUM_LVL-1:0] v;
        v = '0;
        if (l != '0) begin
            v[l - 1'b1] = 1'b1;
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [SRC_N-1:0] wdata,
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] dis,
    input  logic [CPU_W-1:0] target,
    output wr_cmd_t          cmd,
    output logic [SRC_N-1:0] rdata
);

    always_comb begin
        cmd          = '0;
        cmd.bits     = wdata & LIVE_BITS;
        cmd.raw      = wdata;
        if (wr_en) begin
            unique case (addr)
                IDX_UNMASK: cmd.unmask   = 1'b1;
                IDX_MASK:   cmd.mask     = 1'b1;
                IDX_TARGET: cmd.retarget = 1'b1;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr)
            IDX_PEND:   rdata = pend & ~(SRC_N'(1) << MOFF_BIT);
            IDX_DIS:    rdata = dis & LIVE_BITS;
            IDX_TARGET: rdata = SRC_N'(target);
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_pend_state.sv
module irq_pend_state
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int TIMER_BIT = 19,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_cmd_t          cmd,
    input  logic [SRC_N-1:0] dev_irq,
    input  logic [NUM_CPU-1:0] timer_irq,
    output logic [SRC_N-1:0] pend,
    output logic [SRC_N-1:0] dis,
    output logic [CPU_W-1:0] target,
    output logic [SRC_N-1:0] dev_rise
);

    localparam logic [SRC_N-1:0] TBIT = SRC_N'(1) << TIMER_BIT;

    logic [SRC_N-1:0]   dev_q;
    logic [NUM_CPU-1:0] tmr_q;
    edge_evt_t          evt;
    logic               t_rise, t_fall;
    logic [SRC_N-1:0]   wclr;
    logic [SRC_N-1:0]   pend_n, dis_n;
    logic [CPU_W-1:0]   target_n;

    always_comb begin
        dev_rise  = dev_irq & ~dev_q;
        t_rise    = |(timer_irq & ~tmr_q);
        t_fall    = |(~timer_irq & tmr_q);
        evt.set_v = dev_rise | (t_rise ? TBIT : '0);
        evt.clr_v = (~dev_irq & dev_q) | (t_fall ? TBIT : '0);
    end

    always_comb begin
        wclr     = cmd.mask ? cmd.bits : '0;
        pend_n   = ((pend & ~wclr) & ~evt.clr_v) | evt.set_v;
        dis_n    = dis;
        if (cmd.mask) begin
            dis_n = dis | cmd.bits;
        end else if (cmd.unmask) begin
            dis_n = dis & ~cmd.bits;
        end
        target_n = cmd.retarget ? cmd.raw[CPU_W-1:0] : target;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_q  <= '0;
            tmr_q  <= '0;
            pend   <= '0;
            dis    <= ABSENT_BITS;
            target <= '0;
        end else begin
            dev_q  <= dev_irq;
            tmr_q  <= timer_irq;
            pend   <= pend_n;
            dis    <= dis_n;
            target <= target_n;
        end
    end

endmodule

// File: rtl/irq_level_map.sv
module irq_level_map
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter logic [SRC_N*LVL_W-1:0] LVL_TABLE = default_lvl_table(),
    localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int OUT_W  = NUM_CPU * NUM_LVL
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] pend,
    input  logic [SRC_N-1:0] dis,
    input  logic [CPU_W-1:0] target,
    input  logic [OUT_W-1:0] soft_irq,
    output logic [OUT_W-1:0] level_req
);

    logic [SRC_N-1:0]   routed;
    logic [NUM_LVL-1:0] dev_lvl;
    logic               route_on;

    always_comb begin
        routed   = pend & ~dis;
        route_on = ~dis[MOFF_BIT];
        dev_lvl  = '0;
        for (int j = 0; j < SRC_N; j++) begin
            if (routed[j]) begin
                dev_lvl = dev_lvl | lvl_onehot(LVL_TABLE[j*LVL_W +: LVL_W]);
            end
        end
    end

    for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
        logic               is_tgt;
        logic [NUM_LVL-1:0] lvl_n;

        always_comb begin
            is_tgt = route_on && (target == CPU_W'(k));
            lvl_n  = soft_irq[k*NUM_LVL +: NUM_LVL] | (is_tgt ? dev_lvl : '0);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                level_req[k*NUM_LVL +: NUM_LVL] <= '0;
            end else begin
                level_req[k*NUM_LVL +: NUM_LVL] <= lvl_n;
            end
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int TIMER_BIT = 19,
    parameter logic [SRC_N*LVL_W-1:0] LVL_TABLE = default_lvl_table(),
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int OUT_W    = NUM_CPU * NUM_LVL
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2:0]         addr,
    input  logic [SRC_N-1:0]   wdata,
    output logic [SRC_N-1:0]   rdata,
    input  logic [SRC_N-1:0]   dev_irq,
    input  logic [NUM_CPU-1:0] timer_irq,
    input  logic [OUT_W-1:0]   soft_irq,
    output logic [OUT_W-1:0]   level_req
);

    wr_cmd_t          cmd;
    logic [SRC_N-1:0] pend;
    logic [SRC_N-1:0] dis;
    logic [CPU_W-1:0] target;
    logic [SRC_N-1:0] dev_rise;

    irq_reg_decode #(.NUM_CPU(NUM_CPU)) u_dec (
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .pend   (pend),
        .dis    (dis),
        .target (target),
        .cmd    (cmd),
        .rdata  (rdata)
    );

    irq_pend_state #(.NUM_CPU(NUM_CPU), .TIMER_BIT(TIMER_BIT)) u_state (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .dev_irq   (dev_irq),
        .timer_irq (timer_irq),
        .pend      (pend),
        .dis       (dis),
        .target    (target),
        .dev_rise  (dev_rise)
    );

    irq_level_map #(.NUM_CPU(NUM_CPU), .LVL_TABLE(LVL_TABLE)) u_map (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend),
        .dis       (dis),
        .target    (target),
        .soft_irq  (soft_irq),
        .level_req (level_req)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU   = 4,
    parameter int TIMER_BIT = 19,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int OUT_W    = NUM_CPU * NUM_LVL
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [2:0]         addr,
    input logic [SRC_N-1:0]   wdata,
    input logic [OUT_W-1:0]   soft_irq,
    input logic [OUT_W-1:0]   level_req,
    input logic [SRC_N-1:0]   pend,
    input logic [SRC_N-1:0]   dis,
    input logic [CPU_W-1:0]   target,
    input logic [SRC_N-1:0]   dev_rise
);

    localparam logic [SRC_N-1:0] NOT_TBIT = ~(SRC_N'(1) << TIMER_BIT);

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (level_req == '0 && pend == '0 && target == '0));

    // R4
    unmask_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd2) |=> ((dis & $past(wdata & LIVE_BITS)) == '0));

    // R5
    mask_drops_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd3 && dev_rise == '0)
        |=> ((pend & ~(SRC_N'(1) << TIMER_BIT) & $past(wdata & LIVE_BITS)) == '0
             && (dis & $past(wdata & LIVE_BITS)) == $past(wdata & LIVE_BITS)));

    // R6
    target_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 3'd4) |=> (target == $past(wdata[CPU_W-1:0])));

    // R7
    master_off_chk: assert property (@(posedge clk) disable iff (rst)
        (dis[MOFF_BIT]) |=> (level_req == $past(soft_irq)));

    // R9
    rise_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_rise != '0) |=> ((pend & $past(dev_rise & NOT_TBIT)) == $past(dev_rise & NOT_TBIT)));

endmodule

bind irq_router irq_router_chk #(.NUM_CPU(NUM_CPU), .TIMER_BIT(TIMER_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .soft_irq  (soft_irq),
    .level_req (level_req),
    .pend      (pend),
    .dis       (dis),
    .target    (target),
    .dev_rise  (dev_rise)
);

// File: tb/irq_router_tb.sv
module irq_router_tb;

    localparam int CLK_NS = 10;
    localparam int NCPU   = 4;
    localparam int TB_BIT = 19;
    localparam int OW     = NCPU * 15;
    localparam logic [31:0] LIVE = 32'hf05dff80;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [2:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [31:0]   dev_irq;
    logic [NCPU-1:0] timer_irq;
    logic [OW-1:0] soft_irq;
    logic [OW-1:0] level_req;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    logic [31:0]   m_pend, m_dis, m_devq;
    logic [1:0]    m_tgt;
    logic [NCPU-1:0] m_tq;
    logic [OW-1:0] m_lvl;

    always #(CLK_NS/2) clk = ~clk;

    irq_router u_dut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr), .wdata (wdata),
        .rdata (rdata), .dev_irq (dev_irq), .timer_irq (timer_irq),
        .soft_irq (soft_irq), .level_req (level_req)
    );

    function automatic logic [31:0] m_rd(input logic [2:0] a);
        case (a)
            3'd0:    return m_pend & 32'h7fffffff;
            3'd1:    return m_dis & LIVE;
            3'd4:    return {30'd0, m_tgt};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [2:0] a);
        case (a)
            3'd0:    return "R2";
            3'd4:    return "R6";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [14:0] m_map(input logic [31:0] r);
        logic [14:0] v = '0;
        for (int j = 0; j < 32; j++) if (r[j]) v[j % 15] = 1'b1;
        return v;
    endfunction

    task automatic check(input logic [OW-1:0] act, input logic [OW-1:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic m_reset();
        m_pend = '0; m_dis = 32'h0fa2007f; m_devq = '0; m_tgt = '0; m_tq = '0; m_lvl = '0;
    endtask

    // Reference update at a clock edge; levels use pre-edge state (R11)
    task automatic m_edge();
        logic [OW-1:0] nl;
        logic [31:0] setv, clrv, wclr;
        for (int k = 0; k < NCPU; k++) begin
            nl[k*15 +: 15] = soft_irq[k*15 +: 15] |
                ((k == m_tgt && !m_dis[31]) ? m_map(m_pend & ~m_dis) : 15'd0);
        end
        m_lvl = nl;
        setv = (dev_irq & ~m_devq) | ((|(timer_irq & ~m_tq)) ? (32'd1 << TB_BIT) : 32'd0);
        clrv = (~dev_irq & m_devq) | ((|(~timer_irq & m_tq)) ? (32'd1 << TB_BIT) : 32'd0);
        wclr = '0;
        if (wr_en) begin
            case (addr)
                3'd2: m_dis = m_dis & ~(wdata & LIVE);
                3'd3: begin m_dis = m_dis | (wdata & LIVE); wclr = wdata & LIVE; end
                3'd4: m_tgt = 2'(wdata % NCPU);
                default: ;
            endcase
        end
        m_pend = ((m_pend & ~wclr) & ~clrv) | setv;
        m_devq = dev_irq;
        m_tq   = timer_irq;
    endtask

    task automatic step(input logic w, input logic [2:0] a, input logic [31:0] d,
                        input logic [31:0] dv, input logic [NCPU-1:0] tm,
                        input logic [OW-1:0] sf, input string tag);
        wr_en = w; addr = a; wdata = d; dev_irq = dv; timer_irq = tm; soft_irq = sf;
        #1;
        check(OW'(rdata), OW'(m_rd(a)), {rd_tag(a), " ", tag});
        @(posedge clk);
        m_edge();
        @(negedge clk);
        check(level_req, m_lvl, {(m_dis[31] ? "R7" : "R8"), " ", tag});
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] dv;
        logic [NCPU-1:0] tm;
        logic [OW-1:0] sf;
        void'($urandom(32'd4242));
        rst = 1'b1; wr_en = 0; addr = 0; wdata = 0; dev_irq = 0; timer_irq = 0; soft_irq = 0;
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state through each read index
        step(0, 3'd0, 0, 0, 0, 0, "R1");
        step(0, 3'd1, 0, 0, 0, 0, "R1");
        step(0, 3'd4, 0, 0, 0, 0, "R1");
        // R9 R11 line 7 to cpu0 at level 8
        step(0, 3'd0, 0, 32'h80, 0, 0, "R9");
        step(0, 3'd0, 0, 32'h80, 0, 0, "R11");
        check(level_req, OW'(15'h0080), "R8 line7 level8 cpu0");
        // R6 target modulo: write 6 selects cpu 2
        step(1, 3'd4, 32'd6, 32'h80, 0, 0, "R6");
        step(0, 3'd4, 0, 32'h80, 0, 0, "R6");
        check(level_req, OW'(15'h0080) << 30, "R8 moved to cpu2");
        // R5 mask all: pending dropped, R3 read masked
        step(1, 3'd3, 32'hffffffff, 32'h80, 0, 0, "R5");
        step(0, 3'd1, 0, 32'h80, 0, 0, "R3");
        step(0, 3'd0, 0, 32'h80, 0, 0, "R5");
        // R4 unmask all but global bit; R7 soft only while global off
        step(1, 3'd2, 32'h7fffffff, 32'h180, 0, OW'(15'h0008) << 15, "R4");
        step(0, 3'd0, 0, 32'h180, 0, OW'(15'h0008) << 15, "R7");
        step(0, 3'd1, 0, 32'h180, 0, OW'(15'h0008) << 15, "R7");
        check(level_req, OW'(15'h0008) << 15, "R7 soft only");
        step(1, 3'd2, 32'h80000000, 32'h180, 0, 0, "R4");
        step(0, 3'd0, 0, 32'h180, 0, 0, "R8");
        // R10 timer from non-target cpu3, then same-cycle device clear
        step(0, 3'd0, 0, 32'h180, 4'b1000, 0, "R10");
        step(0, 3'd0, 0, 32'h180 | (32'd1 << TB_BIT), 4'b1000, 0, "R10");
        step(0, 3'd0, 0, 32'h180, 4'b0000, 0, "R10");
        step(0, 3'd0, 0, 32'h180, 0, 0, "R10");
        // R2 line 31 pending hidden on read; R3 unused indices; R4 no-op writes
        step(0, 3'd0, 0, 32'h80000180, 0, 0, "R2");
        step(0, 3'd0, 0, 32'h80000180, 0, 0, "R2");
        for (int a = 5; a < 8; a++) step(1, 3'(a), 32'hffffffff, 32'h80000180, 0, 0, "R3");
        step(1, 3'd0, 32'hffffffff, 32'h80000180, 0, 0, "R4");
        step(1, 3'd1, 32'hffffffff, 32'h80000180, 0, 0, "R4");
        // R5 mask write racing a rising edge
        step(1, 3'd3, 32'h00000200, 32'h80000380, 0, 0, "R5");
        step(0, 3'd0, 0, 32'h80000380, 0, 0, "R5");
        // Random phase
        dv = 32'h80000380; tm = 0; sf = 0;
        for (int i = 0; i < 1500; i++) begin
            logic w;
            dv = dv ^ ($urandom & $urandom & $urandom);
            if (($urandom % 4) == 0) tm = tm ^ NCPU'($urandom);
            if (($urandom % 8) == 0) sf = {$urandom, $urandom} & {$urandom, $urandom};
            w = (($urandom % 4) == 0);
            step(w, 3'($urandom), $urandom, dv, tm, sf, "R8 R9 random");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule